// File: doc/BRIEF.md
# MDIO Station Management Controller

This block lets a host on a simple register port run Clause 22 management frames to an external PHY. The host sees two 16-bit registers. The command register holds the PHY address, the PHY register number, a clock-range code, a direction flag and a busy flag. The data register holds the value to send on a write, and it returns the captured value after a read.

A single write to the command register with the busy flag set launches a whole frame. The block makes the management clock (MDC) by dividing the system clock by a ratio chosen with the clock-range code. It shifts the frame out on the MDIO pin through a separate output-enable. On a read it samples the PHY's answer on the rising edges of MDC. The busy flag clears by itself at the end of the frame. A command write with the busy flag clear runs a single MDC period with MDIO released, which gives a PHY the clock edge it needs to leave reset.

Top module: `smi_ctrl`

## Requirements
- R1: After reset both registers read zero, and MDC and the output-enable are low.
- R2: The command register is laid out as follows: bit 0 is busy, bit 1 is the direction (1 = write, 0 = read), bits 5:2 are the clock-range code, bits 10:6 are the PHY register number and bits 15:11 are the PHY address. When a frame ends, the register reads back the launched value with bit 0 cleared.
- R3: Busy reads 1 from the cycle after the launching write. It returns to 0 only when the frame ends, which is after the final MDC rising edge.
- R4: A write frame is sent MSB first. It consists of 32 preamble ones, the start bits 01, the opcode 01, the 5-bit PHY address, the 5-bit register number, the turnaround bits 10 and the 16 data bits. The output-enable is high for all 64 bits.
- R5: A read frame sends the preamble, start 01, opcode 10 and both addresses with the output-enable high. The output-enable is low for both turnaround bits and all 16 data bits.
- R6: On a read, the 16 bits sampled on the MDC rising edges of the data phase, MSB first, are in the data register when busy clears.
- R7: The MDC period in system clocks is 42, 62, 16, 26, 102 and 124 for codes 0 to 5, and 124 for codes 6 to 15. The high and low phases are equal.
- R8: While MDC is high, MDIO output does not change. New bits appear only at MDC falling edges.
- R9: A command write with bit 0 clear, including a write of zero, produces exactly one MDC period. The output-enable stays low and busy stays 0.
- R10: A command write while a frame is in progress is ignored.
- R11: A data-register write while a frame is in progress is ignored.
- R12: Register reads are combinational. Address 0 selects the command register and address 1 selects the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write access |
| reg_addr | input | 1 | 0 = command register, 1 = data register |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output-enable |
| mdio_i | input | 1 | MDIO input from the pin |

## Verification
A wrong bit counter or shift register shows up as a corrupted frame at MDC rate. The scoreboard compares every bit of each frame against the expected frame, so a single misplaced bit is reported at that frame's last rising edge. A bad output-enable sequence is caught there too. A wrong divider state changes the measured MDC period on the second rising edge of a frame. A stuck or early-cleared busy flag appears in the readback poll. Either the frame has not finished when busy drops, or the poll never ends and the watchdog fires. A lost lock on the registers during a frame shows up in the readback taken right after busy clears.

// File: rtl/smi_pkg.sv
package smi_pkg;

   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;
   localparam int CODE_W = 4;

   // command register; field order is the software-visible layout
   typedef struct packed {
      logic [ADDR_W-1:0] phy;    // 15:11
      logic [ADDR_W-1:0] regnum; // 10:6
      logic [CODE_W-1:0] range;  // 5:2
      logic              wr;     // 1
      logic              busy;   // 0
   } cmd_t;

   // MDC period in system clocks for each clock-range code
   function automatic logic [7:0] mdc_ratio(input logic [CODE_W-1:0] code);
      logic [7:0] r;
      case (code)
         4'd0:    r = 8'd42;
         4'd1:    r = 8'd62;
         4'd2:    r = 8'd16;
         4'd3:    r = 8'd26;
         4'd4:    r = 8'd102;
         default: r = 8'd124;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/smi_clkgen.sv
module smi_clkgen #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);

   logic [CNT_W-1:0] cnt_q;
   logic             mdc_q;
   logic             tick;

   assign tick = run && (cnt_q == half - CNT_W'(1));
   assign rise = tick && !mdc_q;
   assign fall = tick && mdc_q;
   assign mdc  = mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         mdc_q <= !mdc_q;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/smi_shifter.sv
module smi_shifter
   import smi_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dummy,
   input  logic              wr,
   input  logic [ADDR_W-1:0] phy,
   input  logic [ADDR_W-1:0] regnum,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise,
   input  logic              fall,
   input  logic              mdi,
   output logic              run,
   output logic              done,
   output logic              mdo,
   output logic              oe,
   output logic [DATA_W-1:0] cap
);

   localparam int TOTAL   = PRE_LEN + 2 + 2 + 2*ADDR_W + 2 + DATA_W;
   localparam int IW      = $clog2(TOTAL);
   localparam int TA_IDX  = PRE_LEN + 4 + 2*ADDR_W;
   localparam int DAT_IDX = TA_IDX + 2;

   logic [TOTAL-1:0]  sh_q;
   logic [TOTAL-1:0]  frame;
   logic [IW-1:0]     idx_q;
   logic              active_q, dummy_q, wr_q, oe_q;
   logic [DATA_W-1:0] cap_q;
   logic              last;

   assign frame = {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, regnum,
                   2'b10, (wr ? wdata : {DATA_W{1'b1}})};
   assign last  = dummy_q || (idx_q == IW'(TOTAL-1));
   assign done  = active_q && fall && last;
   assign run   = active_q;
   assign mdo   = sh_q[TOTAL-1];
   assign oe    = oe_q;
   assign cap   = cap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q     <= '0;
         idx_q    <= '0;
         active_q <= 1'b0;
         dummy_q  <= 1'b0;
         wr_q     <= 1'b0;
         oe_q     <= 1'b0;
         cap_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         dummy_q  <= dummy;
         wr_q     <= wr;
         oe_q     <= !dummy;
         sh_q     <= frame;
         idx_q    <= '0;
      end else if (active_q) begin
         if (rise && !dummy_q && !wr_q && idx_q >= IW'(DAT_IDX))
            cap_q <= {cap_q[DATA_W-2:0], mdi};
         if (fall) begin
            if (last) begin
               active_q <= 1'b0;
               oe_q     <= 1'b0;
            end else begin
               idx_q <= idx_q + IW'(1);
               sh_q  <= {sh_q[TOTAL-2:0], 1'b1};
               if (!wr_q && idx_q == IW'(TA_IDX-1))
                  oe_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/smi_ctrl.sv
module smi_ctrl
   import smi_pkg::*;
#(
   parameter int PRE_LEN     = 32,
   parameter int CNT_W       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_valid,
   input  logic        reg_write,
   input  logic        reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
      $error("smi_ctrl: PRE_LEN out of range");
   end
   if (CNT_W < 6) begin : g_bad_cnt
      $error("smi_ctrl: CNT_W too narrow for largest half period");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("smi_ctrl: SYNC_STAGES must be 0..3");
   end

   cmd_t              cmd_q, cmd_in;
   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  half_q;
   logic              xfer_run, xfer_done;
   logic              mdc_rise, mdc_fall;
   logic [DATA_W-1:0] cap;
   logic              mdi_s;
   logic              wr_cmd, wr_dat, launch;

   assign cmd_in = cmd_t'(reg_wdata);
   assign wr_cmd = reg_valid && reg_write && !reg_addr;
   assign wr_dat = reg_valid && reg_write && reg_addr;
   assign launch = wr_cmd && !xfer_run;

   assign reg_rdata = reg_addr ? data_q : 16'(cmd_q);

   // input synchronizer variant chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign mdi_s = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] st_q;
      always_ff @(posedge clk) begin
         if (!rst_n) st_q <= '1;
         else begin
            st_q[0] <= mdio_i;
            for (int i = 1; i < SYNC_STAGES; i++) st_q[i] <= st_q[i-1];
         end
      end
      assign mdi_s = st_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         data_q <= '0;
         half_q <= CNT_W'(8);
      end else begin
         if (launch) begin
            cmd_q  <= cmd_in;
            half_q <= CNT_W'(mdc_ratio(cmd_in.range) >> 1);
         end else if (xfer_done) begin
            cmd_q.busy <= 1'b0;
            if (cmd_q.busy && !cmd_q.wr) data_q <= cap;
         end
         if (wr_dat && !xfer_run) data_q <= reg_wdata;
      end
   end

   smi_clkgen #(.CNT_W(CNT_W)) u_clk (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (xfer_run),
      .half (half_q),
      .mdc  (mdc),
      .rise (mdc_rise),
      .fall (mdc_fall)
   );

   smi_shifter #(.PRE_LEN(PRE_LEN)) u_shf (
      .clk   (clk),
      .rst_n (rst_n),
      .start (launch),
      .dummy (!cmd_in.busy),
      .wr    (cmd_in.wr),
      .phy   (cmd_in.phy),
      .regnum(cmd_in.regnum),
      .wdata (data_q),
      .rise  (mdc_rise),
      .fall  (mdc_fall),
      .mdi   (mdi_s),
      .run   (xfer_run),
      .done  (xfer_done),
      .mdo   (mdio_o),
      .oe    (mdio_oe),
      .cap   (cap)
   );

endmodule

// File: rtl/smi_chk.sv
module smi_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_valid,
   input logic        reg_write,
   input logic        reg_addr,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic [15:0] cmd_q,
   input logic        xfer_run,
   input logic        xfer_done
);

   AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_q[0] |-> !mdio_oe); // R9

   AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_run |-> !mdc); // R9

   AST_MDO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> $stable(mdio_o)); // R8

   AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_run && !xfer_done && reg_valid && reg_write && !reg_addr) |=> $stable(cmd_q)); // R10

   AST_BUSY_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_q[0]) |-> $past(xfer_done)); // R3

endmodule

bind smi_ctrl smi_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_valid(reg_valid),
   .reg_write(reg_write),
   .reg_addr (reg_addr),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .cmd_q    (cmd_q),
   .xfer_run (xfer_run),
   .xfer_done(xfer_done)
);

// File: tb/sim_smi_ctrl.sv
`timescale 1ns/1ps
module sim_smi_ctrl;

   localparam int PRE   = 32;
   localparam int TOTAL = PRE + 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0, reg_write = 1'b0, reg_addr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #5 clk = ~clk;

   smi_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   typedef struct {
      logic [TOTAL-1:0] bits;
      logic             is_rd;
      logic [15:0]      rd;
   } item_t;

   item_t q[$];
   int checks = 0, fails = 0, cyc = 0;
   logic mon_en = 1'b1;
   int ridx = 0, last_rise = 0, period_seen = 0, rise_total = 0, hold_err = 0;
   logic oe_seen = 1'b0, prev_mdc = 1'b0, prev_mdo = 1'b0;
   logic [TOTAL-1:0] got_bits, got_oe;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ratio(input logic [3:0] c);
      case (c)
         4'd0: return 8'd42;
         4'd1: return 8'd62;
         4'd2: return 8'd16;
         4'd3: return 8'd26;
         4'd4: return 8'd102;
         default: return 8'd124;
      endcase
   endfunction

   // PHY model: value to present for frame bit n
   function automatic logic phy_bit(input int n);
      if (q.size() == 0 || !q[0].is_rd) return 1'b1;
      if (n == PRE + 15) return 1'b0;
      if (n >= PRE + 16 && n < PRE + 32) return q[0].rd[15 - (n - PRE - 16)];
      return 1'b1;
   endfunction

   // monitor: collects frame bits and compares against scoreboard
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (mdio_oe) oe_seen = 1'b1;
            if (prev_mdc && mdc && mdio_o !== prev_mdo) hold_err++;
            if (!prev_mdc && mdc) begin
               rise_total++;
               if (mon_en) begin
                  if (ridx == 1) period_seen = cyc - last_rise;
                  last_rise = cyc;
                  got_bits[TOTAL-1-ridx] = mdio_o;
                  got_oe[TOTAL-1-ridx]   = mdio_oe;
                  ridx++;
                  if (ridx == TOTAL) begin
                     ridx = 0;
                     if (q.size() == 0) chk(1'b0, "R4", "unexpected frame", 64'd1, 64'd0);
                     else begin
                        item_t e;
                        logic [TOTAL-1:0] eoe;
                        e = q.pop_front();
                        eoe = e.is_rd ? ~({TOTAL{1'b1}} >> (PRE + 14)) : {TOTAL{1'b1}};
                        chk(((got_bits ^ e.bits) & eoe) == '0, e.is_rd ? "R5" : "R4",
                            "frame bits", got_bits, e.bits);
                        chk(got_oe == eoe, e.is_rd ? "R5" : "R4", "output-enable", got_oe, eoe);
                     end
                  end
               end
            end
            if (prev_mdc && !mdc && mon_en) mdio_i = phy_bit(ridx);
         end
         prev_mdc = mdc;
         prev_mdo = mdio_o;
      end
   end

   task automatic reg_wr(input logic a, input logic [15:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic reg_rd(input logic a, output logic [15:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   // driver: pushes expected frame and runs one transaction
   task automatic xfer(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [3:0] code, input logic [15:0] wd,
                       input logic [15:0] rd, input bit meddle);
      item_t it;
      logic [15:0] cmd, v;
      it.bits  = {{PRE{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10,
                  (wr ? wd : 16'hFFFF)};
      it.is_rd = !wr;
      it.rd    = rd;
      q.push_back(it);
      cmd = {phy, ra, code, wr, 1'b1};
      if (wr) reg_wr(1'b1, wd);
      reg_wr(1'b0, cmd);
      reg_rd(1'b0, v);
      chk(v[0] == 1'b1, "R3", "busy after launch", v, cmd);
      if (meddle) begin
         repeat (40) @(negedge clk);
         reg_wr(1'b0, ~cmd | 16'h0001);
         reg_wr(1'b1, 16'hDEAD);
      end
      do reg_rd(1'b0, v); while (v[0]);
      chk(v == (cmd & 16'hFFFE), meddle ? "R10" : "R2", "command readback", v, cmd & 16'hFFFE);
      chk(q.size() == 0, "R3", "frame finished before busy cleared", q.size(), 0);
      chk(period_seen == int'(ratio(code)), "R7", "MDC period", period_seen, ratio(code));
      reg_rd(1'b1, v);
      if (!wr) chk(v == rd, meddle ? "R11" : "R6", "read data", v, rd);
      else     chk(v == wd, meddle ? "R11" : "R12", "data register", v, wd);
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int r0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      reg_rd(1'b0, v); chk(v == 16'h0, "R1", "command after reset", v, 0);
      reg_rd(1'b1, v); chk(v == 16'h0, "R1", "data after reset", v, 0);
      chk(mdc == 1'b0, "R1", "mdc after reset", mdc, 0);
      chk(mdio_oe == 1'b0, "R1", "oe after reset", mdio_oe, 0);
      // R12 register select
      reg_wr(1'b1, 16'h1234);
      reg_rd(1'b1, v); chk(v == 16'h1234, "R12", "data select", v, 16'h1234);
      reg_rd(1'b0, v); chk(v == 16'h0000, "R12", "command select", v, 0);
      // R9 write of zero yields one MDC period
      mon_en = 1'b0; oe_seen = 1'b0; r0 = rise_total;
      reg_wr(1'b0, 16'h0000);
      repeat (200) @(negedge clk);
      chk(rise_total - r0 == 1, "R9", "MDC rises for zero write", rise_total - r0, 1);
      chk(!oe_seen, "R9", "oe during zero write", oe_seen, 0);
      chk(mdc == 1'b0, "R9", "mdc idle after pulse", mdc, 0);
      reg_rd(1'b0, v); chk(v == 16'h0, "R9", "busy stays clear", v, 0);
      oe_seen = 1'b0; r0 = rise_total;
      reg_wr(1'b0, 16'hA40A);
      repeat (60) @(negedge clk);
      chk(rise_total - r0 == 1, "R9", "MDC rises for non-busy write", rise_total - r0, 1);
      chk(!oe_seen, "R9", "oe during non-busy write", oe_seen, 0);
      mon_en = 1'b1;
      // frames
      xfer(1'b1, 5'h13, 5'h0A, 4'd2, 16'hA55A, 16'h0000, 1'b0);
      xfer(1'b0, 5'h01, 5'h1F, 4'd2, 16'h0000, 16'hC3E1, 1'b0);
      xfer(1'b0, 5'h1E, 5'h00, 4'd3, 16'h0000, 16'h8001, 1'b0);
      xfer(1'b1, 5'h00, 5'h11, 4'd0, 16'h5AA5, 16'h0000, 1'b1);
      xfer(1'b0, 5'h0C, 5'h05, 4'd1, 16'h0000, 16'h7FFE, 1'b1);
      xfer(1'b1, 5'h1F, 5'h1F, 4'd4, 16'hFFFF, 16'h0000, 1'b0);
      xfer(1'b0, 5'h15, 5'h0B, 4'd5, 16'h0000, 16'h0000, 1'b0);
      xfer(1'b1, 5'h0A, 5'h15, 4'd9, 16'h0F0F, 16'h0000, 1'b0);
      chk(hold_err == 0, "R8", "MDIO changed while MDC high", hold_err, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule